// File: doc/BRIEF.md
# Register-Mapped Digital Port Pair with Multiplexer-Address Override

This block gives software two 8-bit digital ports behind a small register bus. The first port is bidirectional. Each of its pins has its own direction bit, and the block drives an output-enable vector and an output-data vector for it. The second port can only be read: it samples its pins and has nothing to drive.

Every pin input passes through a two-stage synchronizer before it reaches read data. A read of the bidirectional port returns a mix of two sources. For a bit set as an output, it returns the output data latch. For a bit set as an input, it returns the synchronized pin level. Because of this, read-modify-write sequences in software do not disturb the output bits.

A mode bit hands the three low pins of the bidirectional port to an external multiplexer address. That address is a 3-bit value held in a latch, which a neighbouring sequencer loads with a strobe. While the mode is on, those three pins are forced to be outputs whatever their direction bits say. They drive the address latch, and reads of those bits return it.

Top module: `gpio_mux_port`

## Requirements
- R1: After reset, the direction register reads 0x00, the mode register reads 0x00 and `portAOe` is 0x00, so all port A pins are inputs with multiplexer mode off.
- R2: Register map (offsets on `regAddr`): 0 = port A data latch, 1 = port B data, 2 = port A direction, 3 = mode control with the multiplexer-mode enable in bit 0. With mode off, `portAOe` equals the direction register (1 = output) and `portAOut` equals the port A data latch.
- R3: A port A read returns the synchronized pin level for each bit whose effective output enable is 0. A pin change first appears in read data after the second rising clock edge following the change.
- R4: A port A read returns the output data latch for each bit whose effective output enable is 1.
- R5: With the mode bit set, `portAOe[2:0]` is 3'b111 and `portAOut[2:0]` equals the multiplexer address latch, whatever the direction bits are. Bits [7:3] follow R2.
- R6: With the mode bit set, port A read bits [2:0] return the multiplexer address latch, whatever the direction bits are.
- R7: The multiplexer address latch takes `muxAddrIn` at a rising edge where `muxAddrLoad` is 1, and otherwise holds its value.
- R8: Clearing the mode bit returns bits [2:0] to direction-register control at once. The port A data latch keeps its contents, including any write made while the mode was on.
- R9: A write to offset 1 changes no pin output and no output enable. A read of offset 1 returns the synchronized port B pins.
- R10: A read of any offset from 4 to 15 returns 0x00.
- R11: Reset does not clear the port A data latch. A value written before a reset still drives `portAOut` after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 4 | Register offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` (combinational) |
| portAIn | input | 8 | Port A pin levels |
| portBIn | input | 8 | Port B pin levels |
| portAOut | output | 8 | Port A output data |
| portAOe | output | 8 | Port A output enables (1 = drive) |
| muxAddrIn | input | 3 | Multiplexer address from the sequencer |
| muxAddrLoad | input | 1 | Load strobe for the multiplexer address latch |

## Verification
The bench tries random combinations of direction, latch data, mode bit, multiplexer address and pin levels. These combinations separate bits that are read back from the latch from bits read from the pin, and separate bits under direction control from bits under the override.

Directed cases cover the rest:
- Synchronizer latency: the bench reads one edge and then two edges after a pin change, which catches a missing or extra stage.
- Latch hold: the multiplexer input changes without a load strobe.
- Mode clear: the mode is cleared after a data write made while the override was on.
- Dead writes and reads: a write to the input-only port, and reads of every unmapped offset.
- Reset: a reset is applied over a written data latch, which separates the reset registers from the latch that keeps its value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFS_PA_DATA = 0;
  localparam int unsigned OFS_PB_DATA = 1;
  localparam int unsigned OFS_PA_DIR  = 2;
  localparam int unsigned OFS_MODE    = 3;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PA,
    SEL_PB,
    SEL_DIR,
    SEL_MODE
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrDir;
    logic   wrMode;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output strobe_t           strobe
);
  always_comb begin
    strobe = '{wrData: 1'b0, wrDir: 1'b0, wrMode: 1'b0, rdSel: SEL_NONE};
    case (regAddr)
      ADDR_W'(OFS_PA_DATA): begin
        strobe.wrData = regWrEn;
        strobe.rdSel  = SEL_PA;
      end
      ADDR_W'(OFS_PB_DATA): strobe.rdSel = SEL_PB;
      ADDR_W'(OFS_PA_DIR): begin
        strobe.wrDir = regWrEn;
        strobe.rdSel = SEL_DIR;
      end
      ADDR_W'(OFS_MODE): begin
        strobe.wrMode = regWrEn;
        strobe.rdSel  = SEL_MODE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned MUX_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [PORT_W-1:0] regWrData,
  output logic [PORT_W-1:0] regRdData,
  input  logic [PORT_W-1:0] portAIn,
  input  logic [PORT_W-1:0] portBIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  input  logic [MUX_W-1:0]  muxAddrIn,
  input  logic              muxAddrLoad
);
  localparam logic [PORT_W-1:0] MUX_MASK = PORT_W'((1 << MUX_W) - 1);

  logic [PORT_W-1:0] dataLatch;
  logic [PORT_W-1:0] dirReg;
  logic              muxMode;
  logic [MUX_W-1:0]  muxLatch;
  logic [PORT_W-1:0] syncA;
  logic [PORT_W-1:0] syncB;
  logic [PORT_W-1:0] readA;

  // Port data latch: deliberately without reset
  always_ff @(posedge clk) begin
    if (strobe.wrData) dataLatch <= regWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= '0;
      muxMode <= 1'b0;
    end else begin
      if (strobe.wrDir)  dirReg  <= regWrData;
      if (strobe.wrMode) muxMode <= regWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            muxLatch <= '0;
    else if (muxAddrLoad) muxLatch <= muxAddrIn;
  end

  gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_syncA (
    .clk(clk), .rstN(rstN), .asyncIn(portAIn), .syncOut(syncA)
  );
  gpio_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_syncB (
    .clk(clk), .rstN(rstN), .asyncIn(portBIn), .syncOut(syncB)
  );

  // Override widens the enables and substitutes the low data bits
  always_comb begin
    portAOe  = dirReg;
    portAOut = dataLatch;
    if (muxMode) begin
      portAOe  = dirReg | MUX_MASK;
      portAOut = (dataLatch & ~MUX_MASK) | PORT_W'(muxLatch);
    end
  end

  assign readA = (portAOut & portAOe) | (syncA & ~portAOe);

  always_comb begin
    case (strobe.rdSel)
      SEL_PA:   regRdData = readA;
      SEL_PB:   regRdData = syncB;
      SEL_DIR:  regRdData = dirReg;
      SEL_MODE: regRdData = PORT_W'(muxMode);
      default:  regRdData = '0;
    endcase
  end

  p_dir_oe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !muxMode |-> portAOe == dirReg);
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrDir |=> $stable(dirReg));
  p_out_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdSel == SEL_PA && !muxMode) |-> ((regRdData ^ dataLatch) & dirReg) == '0);
  p_mux_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    muxMode |-> (portAOe & MUX_MASK) == MUX_MASK);
  p_mux_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    (muxMode && strobe.rdSel == SEL_PA) |-> regRdData[MUX_W-1:0] == muxLatch);
  p_mux_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    muxAddrLoad |=> muxLatch == $past(muxAddrIn));
  p_mux_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !muxAddrLoad |=> $stable(muxLatch));
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdSel == SEL_NONE |-> regRdData == '0);
endmodule

// File: rtl/gpio_mux_port.sv
module gpio_mux_port
  import gpio_pkg::*;
#(
  parameter int unsigned PORT_W      = 8,
  parameter int unsigned MUX_W       = 3,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [PORT_W-1:0] regWrData,
  output logic [PORT_W-1:0] regRdData,
  input  logic [PORT_W-1:0] portAIn,
  input  logic [PORT_W-1:0] portBIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  input  logic [MUX_W-1:0]  muxAddrIn,
  input  logic              muxAddrLoad
);
  strobe_t strobe;

  gpio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .strobe(strobe)
  );

  gpio_datapath #(.PORT_W(PORT_W), .MUX_W(MUX_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrData(regWrData),
    .regRdData(regRdData), .portAIn(portAIn), .portBIn(portBIn),
    .portAOut(portAOut), .portAOe(portAOe), .muxAddrIn(muxAddrIn),
    .muxAddrLoad(muxAddrLoad)
  );
endmodule

// File: tb/tb_gpio_mux_port.sv
`timescale 1ns/1ps
module tb_gpio_mux_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [7:0] portAIn = '0;
  logic [7:0] portBIn = '0;
  logic [7:0] portAOut;
  logic [7:0] portAOe;
  logic [2:0] muxAddrIn = '0;
  logic       muxAddrLoad = 1'b0;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  logic [7:0] mData, mDir, mPinA, mPinB;
  logic       mMode;
  logic [2:0] mMux;

  gpio_mux_port dut (.*);

  always #2 clk = ~clk;

  function automatic logic [7:0] expOe();
    return mDir | (mMode ? 8'h07 : 8'h00);
  endfunction
  function automatic logic [7:0] expOut();
    return mMode ? {mData[7:3], mMux} : mData;
  endfunction
  function automatic logic [7:0] expReadA();
    return (expOut() & expOe()) | (mPinA & ~expOe());
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 4'd0) mData = d;
    if (a == 4'd2) mDir = d;
    if (a == 4'd3) mMode = d[0];
  endtask

  task automatic regRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic loadMux(input logic [2:0] v);
    @(negedge clk);
    muxAddrIn = v; muxAddrLoad = 1'b1;
    @(negedge clk);
    muxAddrLoad = 1'b0;
    mMux = v;
  endtask

  task automatic setPins(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    portAIn = a; portBIn = b; mPinA = a; mPinB = b;
    repeat (3) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mDir = '0; mMode = 1'b0; mMux = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'd20240611));
    mData = '0; mDir = '0; mMode = 0; mMux = '0; mPinA = '0; mPinB = '0;
    doReset();

    // R1 reset state
    chk("R1 oe", portAOe, 8'h00);
    regRead(4'd2, rd); chk("R1 dir", rd, 8'h00);
    regRead(4'd3, rd); chk("R1 mode", rd, 8'h00);

    // R3 synchronizer latency, all inputs
    regWrite(4'd0, 8'h00);
    @(negedge clk); regAddr = 4'd0; portAIn = 8'h00; mPinA = 8'h00;
    repeat (3) @(negedge clk);
    portAIn = 8'h5A;
    @(negedge clk); #1 chk("R3 one edge", regRdData, 8'h00);
    @(negedge clk); #1 chk("R3 two edges", regRdData, 8'h5A);
    mPinA = 8'h5A;

    // R2/R4 output bits read latch
    regWrite(4'd0, 8'h3C);
    regWrite(4'd2, 8'hF0);
    chk("R2 oe", portAOe, 8'hF0);
    chk("R2 out", portAOut, 8'h3C);
    regRead(4'd0, rd); chk("R4 mixed read", rd, 8'h3A);

    // R5/R6 override with direction all inputs
    regWrite(4'd2, 8'h00);
    loadMux(3'b101);
    regWrite(4'd3, 8'h01);
    chk("R5 oe", portAOe, 8'h07);
    chk("R5 out", portAOut, 8'h3D);
    regRead(4'd0, rd); chk("R6 read", rd, 8'h5D);

    // R7 hold without strobe
    @(negedge clk); muxAddrIn = 3'b010;
    repeat (2) @(negedge clk);
    chk("R7 hold out", portAOut & 8'h07, 8'h05);
    loadMux(3'b010);
    chk("R7 load out", portAOut & 8'h07, 8'h02);

    // R8 write during mode, then clear
    regWrite(4'd0, 8'hC3);
    chk("R8 masked during mode", portAOut, 8'hC2);
    regWrite(4'd3, 8'h00);
    chk("R8 oe after clear", portAOe, 8'h00);
    chk("R8 latch kept", portAOut, 8'hC3);
    regRead(4'd0, rd); chk("R8 read pins", rd, 8'h5A);

    // R9 port B write has no effect
    regWrite(4'd2, 8'h81);
    setPins(8'h5A, 8'hE7);
    regWrite(4'd1, 8'h18);
    chk("R9 out", portAOut, 8'hC3);
    chk("R9 oe", portAOe, 8'h81);
    regRead(4'd1, rd); chk("R9 read B", rd, 8'hE7);

    // R10 unmapped reads
    for (int a = 4; a < 16; a++) begin
      regRead(4'(a), rd); chk("R10 unmapped", rd, 8'h00);
    end

    // R11 reset keeps data latch
    regWrite(4'd0, 8'hA5);
    regWrite(4'd2, 8'hFF);
    doReset();
    chk("R11 latch after reset", portAOut, 8'hA5);
    chk("R1 oe after second reset", portAOe, 8'h00);

    // Random mix
    for (int i = 0; i < 150; i++) begin
      regWrite(4'd0, 8'($urandom));
      regWrite(4'd2, 8'($urandom));
      regWrite(4'd3, 8'($urandom));
      loadMux(3'($urandom));
      setPins(8'($urandom), 8'($urandom));
      chk("R2 R5 random oe", portAOe, expOe());
      chk("R2 R5 random out", portAOut, expOut());
      regRead(4'd0, rd); chk("R3 R4 R6 random read A", rd, expReadA());
      regRead(4'd1, rd); chk("R9 random read B", rd, mPinB);
      regRead(4'd3, rd); chk("R2 random mode", rd, {7'b0, mMode});
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checkCount, failCount);
    $finish;
  end
endmodule